// File: doc/BRIEF.md
# Soft-mute gain ramp controller

This block fades a stream of signed 16-bit audio samples to silence and back by scaling every sample with a gain that follows an S-shaped trajectory. The trajectory moves slowly near full gain and near silence, and quickly through the middle, so the fade is not heard as a click. A fade is requested by the level of an external pin or of a control bit; either one is enough. Three fade durations are selectable. A busy flag stays high from the first step of a fade-out until the last step of the fade-in that follows it.

Separately, a pulse on the source-change input opens a short window of hard silence while an offset alignment runs upstream. A remain bit suppresses the window, so that a repeated source setting causes no silence. The hard window and the soft fade are independent: the fade keeps stepping while the window is open.

All control decisions are taken on a sample-rate tick, which is a single-cycle strobe. Between ticks the output sample and the busy flag hold their values.

Top module: `softmute_ramp`

## Requirements
- R1: After reset, sampleOut is 0, rampBusy is 0 and the gain is unity (table step 0), so the first tick passes sampleIn unchanged.
- R2: The mute request is mutePin OR muteBit. It is sampled only on clock edges where sampleTick is 1; the gain step and rampBusy change only on such edges.
- R3: rampSel chooses the ticks per gain step: 0 gives DIV_FAST (1), 1 gives DIV_MID (2), 2 and 3 give DIV_SLOW (192). The value is captured when a ramp starts, and a change during the ramp has no effect. A ramp crosses 31 steps.
- R4: rampBusy becomes 1 on the tick that starts a fade-out, stays 1 while muted, and returns to 0 on the tick that completes the fade-in. A one-tick request at D ticks per step keeps rampBusy high for 62*D clock cycles when a tick occurs every cycle.
- R5: A started ramp always runs to its last step; request changes during it are ignored.
- R6: On the tick that completes a ramp the request is sampled again. If its level calls for the opposite state, the opposite ramp starts on that same tick and rampBusy does not drop.
- R7: The gain for step i (0..31, N=31) is 32768 - floor(32768*(3*i*i*N - 2*i*i*i)/(N*N*N)), unsigned Q1.15: 32768 at step 0, 0 at step 31.
- R8: On every tick, sampleOut = saturate16((sampleIn*gain + 16384) >>> 15), with arithmetic shift and the gain of the current step. Between ticks sampleOut holds.
- R9: A source-change pulse with remainBit 0 forces sampleOut to 0 on the next ALIGN_TICKS (15) ticks. A new pulse inside the window restarts it.
- R10: A source-change pulse with remainBit 1 has no effect on sampleOut.
- R11: The hard window does not pause or alter the soft ramp. The gain keeps stepping and rampBusy follows R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Sample-rate strobe, one cycle wide |
| mutePin | input | 1 | External mute request level |
| muteBit | input | 1 | Register mute request level |
| rampSel | input | 2 | Fade duration select |
| srcChange | input | 1 | Pulse marking an input source change |
| remainBit | input | 1 | Suppresses the alignment window |
| sampleIn | input | 16 | Signed input sample |
| sampleOut | output | 16 | Signed scaled output sample |
| rampBusy | output | 1 | High from the start of a fade-out until the end of the fade-in |

## Verification
The fade is driven by the pin alone, by the bit alone, and by requests of one tick. With these the bench separates the OR of the two sources, and shows that a started ramp finishes. The busy width is measured at each of the three step rates. A request is raised again during a fade-in to show that the turnaround happens without a gap. Runs with a tick every cycle and with a tick every third cycle, using random sample values and random request toggling, compare each output sample against a behavioural model of the gain curve, the rounding and the saturation. Source-change pulses are applied with and without the remain bit, retriggered inside the window and overlapped with a fade, to show that the hard window is independent of the ramp.

// File: rtl/softmute_pkg.sv
package softmute_pkg;
  parameter int SM_STEPS = 32;
  localparam int SM_IDX_W = $clog2(SM_STEPS);

  typedef enum logic [1:0] {
    ST_OPEN    = 2'd0,
    ST_FALLING = 2'd1,
    ST_SILENT  = 2'd2,
    ST_RISING  = 2'd3
  } rampState_e;

  typedef struct packed {
    logic                tick;
    logic                hardMute;
    logic [SM_IDX_W-1:0] gainIdx;
  } smStrobe_t;
endpackage

// File: rtl/softmute_ctrl.sv
module softmute_ctrl
  import softmute_pkg::*;
#(
  parameter int DIV_FAST    = 1,
  parameter int DIV_MID     = 2,
  parameter int DIV_SLOW    = 192,
  parameter int ALIGN_TICKS = 15
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      mutePin,
  input  logic      muteBit,
  input  logic [1:0] rampSel,
  input  logic      srcChange,
  input  logic      remainBit,
  output smStrobe_t strobe,
  output logic      rampBusy
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_MID) ?
                           ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST) :
                           ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
  localparam int DIV_W = $clog2(DIV_MAX + 1);
  localparam int ALN_W = $clog2(ALIGN_TICKS + 1);
  localparam logic [SM_IDX_W-1:0] IDX_LAST = SM_IDX_W'(SM_STEPS - 1);
  localparam logic [SM_IDX_W-1:0] IDX_FIRST = '0;

  rampState_e          state;
  logic [SM_IDX_W-1:0] gainIdx;
  logic [DIV_W-1:0]    divCnt;
  logic [DIV_W-1:0]    divLimit;
  logic [ALN_W-1:0]    alnCnt;
  logic                muteReq;
  logic                stepDue;
  logic [DIV_W-1:0]    selLimit;

  assign muteReq = mutePin | muteBit;
  assign stepDue = (divCnt == divLimit - 1'b1);

  always_comb begin
    unique case (rampSel)
      2'd0:    selLimit = DIV_W'(DIV_FAST);
      2'd1:    selLimit = DIV_W'(DIV_MID);
      default: selLimit = DIV_W'(DIV_SLOW);
    endcase
  end

  // Ramp sequencer: every decision is taken on a sample tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OPEN;
      gainIdx  <= IDX_FIRST;
      divCnt   <= '0;
      divLimit <= DIV_W'(DIV_FAST);
    end else if (sampleTick) begin
      unique case (state)
        ST_OPEN: begin
          if (muteReq) begin
            state    <= ST_FALLING;
            divCnt   <= '0;
            divLimit <= selLimit;
          end
        end
        ST_FALLING: begin
          if (stepDue) begin
            divCnt  <= '0;
            gainIdx <= gainIdx + 1'b1;
            if (gainIdx + 1'b1 == IDX_LAST) begin
              if (!muteReq) begin
                state    <= ST_RISING;
                divLimit <= selLimit;
              end else begin
                state <= ST_SILENT;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_SILENT: begin
          if (!muteReq) begin
            state    <= ST_RISING;
            divCnt   <= '0;
            divLimit <= selLimit;
          end
        end
        ST_RISING: begin
          if (stepDue) begin
            divCnt  <= '0;
            gainIdx <= gainIdx - 1'b1;
            if (gainIdx - 1'b1 == IDX_FIRST) begin
              if (muteReq) begin
                state    <= ST_FALLING;
                divLimit <= selLimit;
              end else begin
                state <= ST_OPEN;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_OPEN;
      endcase
    end
  end

  // Alignment window counter, loaded on a source change unless remain is set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alnCnt <= '0;
    end else if (srcChange && !remainBit) begin
      alnCnt <= ALN_W'(ALIGN_TICKS);
    end else if (sampleTick && alnCnt != '0) begin
      alnCnt <= alnCnt - 1'b1;
    end
  end

  assign rampBusy        = (state != ST_OPEN);
  assign strobe.tick     = sampleTick;
  assign strobe.hardMute = (alnCnt != '0);
  assign strobe.gainIdx  = gainIdx;

  // R1: the open state always sits at unity gain.
  a_r1_open_unity: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN) |-> (gainIdx == IDX_FIRST));

  // R2: nothing in the sequencer moves without a tick.
  a_r2_tick_gated: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> ($stable(gainIdx) && $stable(rampBusy)));

  // R5: the gain walks the table one step at a time.
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((gainIdx == $past(gainIdx)) ||
              (gainIdx == $past(gainIdx) + 1'b1) ||
              (gainIdx == $past(gainIdx) - 1'b1)));

  // R4: busy only rises when a fade-out begins.
  a_r4_busy_starts_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rampBusy) |-> (state == ST_FALLING && gainIdx == IDX_FIRST));

  // R10: with remain set and no window open, a source change opens none.
  a_r10_remain_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (srcChange && remainBit && alnCnt == '0) |=> (alnCnt == '0));
endmodule

// File: rtl/softmute_datapath.sv
module softmute_datapath
  import softmute_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  smStrobe_t                strobe,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] sampleOut
);
  localparam int  PW    = DATA_W + GAIN_W + 1;
  localparam int  FRAC  = GAIN_W - 1;
  localparam int  CURVE_N = SM_STEPS - 1;
  localparam longint UNITY = 64'sd1 <<< FRAC;
  localparam longint MAXL  = (64'sd1 <<< (DATA_W - 1)) - 1;
  localparam longint MINL  = -(64'sd1 <<< (DATA_W - 1));

  function automatic logic [GAIN_W-1:0] curveGain(input int step);
    longint i;
    longint n;
    longint drop;
    i    = longint'(step);
    n    = longint'(CURVE_N);
    drop = (UNITY * (3 * i * i * n - 2 * i * i * i)) / (n * n * n);
    return GAIN_W'(UNITY - drop);
  endfunction

  logic [GAIN_W-1:0] gainTab [SM_STEPS];

  for (genvar g = 0; g < SM_STEPS; g++) begin : g_curve
    assign gainTab[g] = curveGain(g);
  end

  logic [GAIN_W-1:0]      gainSel;
  logic signed [PW-1:0]   product;
  logic signed [PW-1:0]   rounded;
  logic signed [DATA_W-1:0] clipped;

  assign gainSel = gainTab[strobe.gainIdx];
  assign product = PW'($signed(sampleIn)) * $signed({1'b0, gainSel});
  assign rounded = (product + $signed(PW'(64'sd1 <<< (FRAC - 1)))) >>> FRAC;

  always_comb begin
    if (rounded > $signed(PW'(MAXL))) begin
      clipped = DATA_W'(MAXL);
    end else if (rounded < $signed(PW'(MINL))) begin
      clipped = DATA_W'(MINL);
    end else begin
      clipped = rounded[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut <= '0;
    end else if (strobe.tick) begin
      sampleOut <= strobe.hardMute ? '0 : clipped;
    end
  end

  // R8: the output only updates on a tick.
  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(sampleOut));

  // R9: a tick inside the alignment window produces silence.
  a_r9_window_silent: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && strobe.hardMute) |=> (sampleOut == '0));

  // R7: the last step of the curve gives silence for any input.
  a_r7_last_step_silent: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && strobe.gainIdx == SM_IDX_W'(SM_STEPS - 1)) |=> (sampleOut == '0));
endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp
  import softmute_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int GAIN_W      = 16,
  parameter int DIV_FAST    = 1,
  parameter int DIV_MID     = 2,
  parameter int DIV_SLOW    = 192,
  parameter int ALIGN_TICKS = 15
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleTick,
  input  logic                     mutePin,
  input  logic                     muteBit,
  input  logic [1:0]               rampSel,
  input  logic                     srcChange,
  input  logic                     remainBit,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] sampleOut,
  output logic                     rampBusy
);
  smStrobe_t strobe;

  softmute_ctrl #(
    .DIV_FAST   (DIV_FAST),
    .DIV_MID    (DIV_MID),
    .DIV_SLOW   (DIV_SLOW),
    .ALIGN_TICKS(ALIGN_TICKS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .mutePin   (mutePin),
    .muteBit   (muteBit),
    .rampSel   (rampSel),
    .srcChange (srcChange),
    .remainBit (remainBit),
    .strobe    (strobe),
    .rampBusy  (rampBusy)
  );

  softmute_datapath #(
    .DATA_W(DATA_W),
    .GAIN_W(GAIN_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sampleIn (sampleIn),
    .sampleOut(sampleOut)
  );
endmodule

// File: tb/softmute_ramp_tb.sv
module softmute_ramp_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic mutePin = 1'b0;
  logic muteBit = 1'b0;
  logic [1:0] rampSel = 2'd0;
  logic srcChange = 1'b0;
  logic remainBit = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic signed [15:0] sampleOut;
  logic rampBusy;

  int checks = 0;
  int errors = 0;
  int tickPeriod = 1;
  int tickPhase = 0;
  bit finished = 0;
  string curTag = "R8";

  softmute_ramp u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .mutePin(mutePin),
    .muteBit(muteBit), .rampSel(rampSel), .srcChange(srcChange),
    .remainBit(remainBit), .sampleIn(sampleIn), .sampleOut(sampleOut),
    .rampBusy(rampBusy)
  );

  always #4 clk = ~clk;

  // Reference model: behavioural, updated on every rising edge.
  int mState = 0;   // 0 open, 1 falling, 2 silent, 3 rising
  int mIdx = 0;
  int mCnt = 0;
  int mDiv = 1;
  int mAlign = 0;
  int expOut = 0;
  int expBusy = 0;

  function automatic int refGain(int i);
    longint n = 31;
    longint li = i;
    return int'(32768 - (32768 * (3 * li * li * n - 2 * li * li * li)) / (n * n * n));
  endfunction

  function automatic int refDiv(logic [1:0] s);
    if (s == 2'd0) return 1;
    if (s == 2'd1) return 2;
    return 192;
  endfunction

  function automatic int refScale(int x, int g);
    longint p = (longint'(x) * g + 16384) >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mIdx = 0; mCnt = 0; mDiv = 1; mAlign = 0; expOut = 0; expBusy = 0;
    end else begin
      bit req;
      req = mutePin | muteBit;
      if (sampleTick) expOut = (mAlign > 0) ? 0 : refScale(int'(sampleIn), refGain(mIdx));
      if (srcChange && !remainBit) mAlign = 15;
      else if (sampleTick && mAlign > 0) mAlign = mAlign - 1;
      if (sampleTick) begin
        case (mState)
          0: if (req) begin mState = 1; mCnt = 0; mDiv = refDiv(rampSel); end
          1: if (mCnt == mDiv - 1) begin
               mCnt = 0; mIdx = mIdx + 1;
               if (mIdx == 31) begin
                 if (!req) begin mState = 3; mDiv = refDiv(rampSel); end
                 else mState = 2;
               end
             end else mCnt = mCnt + 1;
          2: if (!req) begin mState = 3; mCnt = 0; mDiv = refDiv(rampSel); end
          default: if (mCnt == mDiv - 1) begin
               mCnt = 0; mIdx = mIdx - 1;
               if (mIdx == 0) begin
                 if (req) begin mState = 1; mDiv = refDiv(rampSel); end
                 else mState = 0;
               end
             end else mCnt = mCnt + 1;
        endcase
      end
      expBusy = (mState != 0) ? 1 : 0;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(int'(sampleOut) == expOut, {curTag, " sampleOut"}, int'(sampleOut), expOut);
      check(int'(rampBusy) == expBusy, {curTag, " rampBusy"}, int'(rampBusy), expBusy);
    end
  end

  // Tick generator, driven at the falling edge.
  always @(negedge clk) begin
    if (tickPhase + 1 >= tickPeriod) begin
      tickPhase <= 0;
      sampleTick <= 1'b1;
    end else begin
      tickPhase <= tickPhase + 1;
      sampleTick <= 1'b0;
    end
  end

  task automatic waitNeg(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic measureBusy(logic [1:0] sel, int expCycles, string tag);
    int cnt = 0;
    rampSel = sel;
    muteBit = 1'b1;
    @(negedge clk);
    muteBit = 1'b0;
    while (rampBusy && cnt < 20000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == expCycles, tag, cnt, expCycles);
    waitNeg(3);
  endtask

  task automatic finish();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    waitNeg(3);
    // R1: reset state
    check(sampleOut == 0, "R1 reset sampleOut", int'(sampleOut), 0);
    check(rampBusy == 0, "R1 reset rampBusy", int'(rampBusy), 0);
    rstN = 1'b1;
    sampleIn = 16'sd12345;
    waitNeg(2);
    check(sampleOut == 12345, "R1 unity after reset", int'(sampleOut), 12345);

    // R2: pin alone mutes, full fade to silence.
    curTag = "R2";
    sampleIn = 16'sd32767;
    mutePin = 1'b1;
    waitNeg(40);
    check(rampBusy == 1, "R2 pin mute busy", int'(rampBusy), 1);
    check(sampleOut == 0, "R7 last step silent", int'(sampleOut), 0);
    mutePin = 1'b0;
    waitNeg(40);
    check(sampleOut == 32767, "R7 back to unity", int'(sampleOut), 32767);
    check(rampBusy == 0, "R4 busy clear after fade-in", int'(rampBusy), 0);

    // R3 / R4 / R5: one-tick requests via the bit at each rate.
    curTag = "R5";
    measureBusy(2'd0, 62, "R3 fast busy width");
    measureBusy(2'd1, 124, "R3 mid busy width");
    measureBusy(2'd3, 11904, "R4 slow busy width");

    // R3: select change during a ramp is ignored.
    curTag = "R3";
    rampSel = 2'd1;
    muteBit = 1'b1;
    waitNeg(2);
    rampSel = 2'd0;
    waitNeg(70);
    check(sampleOut == 0, "R3 captured rate reached silence", int'(sampleOut), 0);

    // R6: request returns during fade-in, turnaround without a gap.
    curTag = "R6";
    begin
      int gaps = 0;
      muteBit = 1'b0;
      waitNeg(5);
      muteBit = 1'b1;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (!rampBusy) gaps++;
      end
      check(gaps == 0, "R6 busy stays high across turnaround", gaps, 0);
      check(sampleOut == 0, "R6 muted again", int'(sampleOut), 0);
    end
    muteBit = 1'b0;
    waitNeg(40);

    // R9: alignment window, then retrigger.
    curTag = "R9";
    sampleIn = 16'sd20000;
    waitNeg(2);
    srcChange = 1'b1;
    @(negedge clk);
    srcChange = 1'b0;
    waitNeg(15);
    check(sampleOut == 0, "R9 window last tick silent", int'(sampleOut), 0);
    @(negedge clk);
    check(sampleOut == 20000, "R9 window closed", int'(sampleOut), 20000);
    srcChange = 1'b1;
    @(negedge clk);
    srcChange = 1'b0;
    waitNeg(8);
    srcChange = 1'b1;
    @(negedge clk);
    srcChange = 1'b0;
    waitNeg(15);
    check(sampleOut == 0, "R9 retrigger extends window", int'(sampleOut), 0);
    waitNeg(3);

    // R10: remain bit suppresses the window.
    curTag = "R10";
    remainBit = 1'b1;
    srcChange = 1'b1;
    @(negedge clk);
    srcChange = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(sampleOut == 20000, "R10 remain keeps signal", int'(sampleOut), 20000);
    end
    remainBit = 1'b0;

    // R11: window overlapping a fade-out.
    curTag = "R11";
    rampSel = 2'd1;
    mutePin = 1'b1;
    waitNeg(10);
    srcChange = 1'b1;
    @(negedge clk);
    srcChange = 1'b0;
    waitNeg(60);
    check(rampBusy == 1, "R11 ramp continued under window", int'(rampBusy), 1);
    mutePin = 1'b0;
    waitNeg(140);

    // R8 / R2: slower ticks with random samples and requests.
    curTag = "R8";
    tickPeriod = 3;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      sampleIn = 16'($urandom);
      if (k % 5 == 0) sampleIn = (k % 2 == 0) ? 16'sh8000 : 16'sh7fff;
      if (($urandom % 97) == 0) mutePin = ~mutePin;
      if (($urandom % 131) == 0) muteBit = ~muteBit;
      if (($urandom % 89) == 0) rampSel = 2'($urandom);
      if (($urandom % 400) == 0) begin
        remainBit = 1'($urandom);
        srcChange = 1'b1;
      end else srcChange = 1'b0;
    end
    srcChange = 1'b0;
    mutePin = 1'b0;
    muteBit = 1'b0;
    waitNeg(10);
    finish();
  end
endmodule